// File: doc/BRIEF.md
# Boot Image Header Validator

This block inspects the fixed header of a boot image while its 32-bit words stream past, each word tagged with its byte offset inside the header. A flash reader or a similar loader drives the stream and pulses a start strobe ahead of each new header. The validator keeps a wrapping 32-bit sum of the words covered by the checksum. It keeps the length, start-address and reserved words, and it remembers which words have arrived.

When the checksum word arrives, the block evaluates every rule in that same cycle and raises a one-cycle done pulse. Alongside the pulse it gives a pass flag and one error bit per rule, and these hold until the next start strobe. The rules cover the checksum and the reserved words. They also cover the alignment and range of the start address, where the range depends on the boot source and on secure mode. The length relation depends on the mode, and a separate rule covers words that never arrived. Fetching from flash, decryption, authentication, register-initialisation pairs and image copying are outside this block.

Top module: `boot_hdr_check`

## Requirements
- R1: The header checksum is the bitwise inverse of the sum, modulo 2^32, of the words at byte offsets 0x020 to 0x044 inclusive. If it differs from the word at offset 0x048, error bit 0 is set.
- R2: If the word at offset 0x038 or the word at offset 0x044 is nonzero, error bit 1 is set.
- R3: If the start address (the word at offset 0x03C) has any of its low 6 bits set, error bit 2 is set.
- R4: With the boot source at 0 (run from on-chip memory), error bit 3 is set in two cases. In secure mode it is set when the start address is not exactly 0. In non-secure mode it is set when the start address is 0x30000 or higher.
- R5: With the boot source at 1 (x4 quad-SPI execute-in-place), error bit 3 is set when the start address is 0x0100_0000 or higher. With the boot source at 2 (NOR or dual x8 quad-SPI execute-in-place), it is set when the start address is 0x0200_0000 or higher. The boot source value 3 always sets error bit 3.
- R6: The total length is the word at offset 0x040 and the image length is the word at offset 0x034. In non-secure mode, error bit 4 is set when the two differ. In secure mode, error bit 4 is set unless the total length is strictly greater than the image length.
- R7: If any offset from 0x020 to 0x044 has not been received when the word at offset 0x048 arrives, error bit 5 is set and pass stays low.
- R8: The cycle after the word at offset 0x048 is accepted, done is high for exactly one cycle. Pass is high exactly when all six error bits are zero. Pass and the error bits hold until the next start strobe.
- R9: A start strobe clears the sum, the kept fields, the received set, pass and the error bits. A word presented in the same cycle as the strobe is ignored. Words are also ignored at offsets outside 0x020 to 0x048, before the first strobe, and after done until the next strobe.
- R10: After reset, done, pass and all error bits are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| start_i | input | 1 | Start-of-header strobe |
| word_vld_i | input | 1 | Header word valid |
| word_off_i | input | 12 | Byte offset of the word within the header |
| word_dat_i | input | 32 | Header word |
| secure_i | input | 1 | Secure boot mode, sampled when the checksum word arrives |
| src_sel_i | input | 2 | Boot source: 0 on-chip memory, 1 x4 quad-SPI in place, 2 NOR or dual x8 quad-SPI in place, 3 invalid |
| done_o | output | 1 | One-cycle pulse when the header is complete |
| pass_o | output | 1 | Header passed all rules |
| err_o | output | 6 | Per-rule errors: 0 checksum, 1 reserved, 2 alignment, 3 address range, 4 length, 5 missing word |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 6 alignment bits, an on-chip limit of 0x30000 and execute-in-place limits of 16 MB and 32 MB. These values put the exact rule boundaries within reach of directed headers, such as 0x2FFC0 against 0x30000 and 0x00FFFFC0 against 0x0100_0000. The filler words are large, so every header sum wraps past 2^32 and exercises the modulo behaviour. Reordered delivery, out-of-window words, a dropped word and a strobe that collides with a word are each driven on their own.

// File: rtl/hdr_chk_pkg.sv
package hdr_chk_pkg;
  // header window, byte offsets
  localparam int unsigned HDR_FIRST = 'h020;
  localparam int unsigned HDR_CSUM  = 'h048;
  localparam int unsigned NWORDS    = (HDR_CSUM - HDR_FIRST) / 4 + 1;
  localparam int unsigned NSUM      = NWORDS - 1;
  localparam int unsigned IDX_W     = $clog2(NWORDS);

  // word index within the window
  localparam int unsigned IDX_IMG   = 5;  // 0x034
  localparam int unsigned IDX_RSV_A = 6;  // 0x038
  localparam int unsigned IDX_START = 7;  // 0x03C
  localparam int unsigned IDX_TOTAL = 8;  // 0x040
  localparam int unsigned IDX_RSV_B = 9;  // 0x044
  localparam int unsigned IDX_CSUM  = 10; // 0x048

  // error vector bit positions
  localparam int unsigned E_CSUM  = 0;
  localparam int unsigned E_RSV   = 1;
  localparam int unsigned E_ALIGN = 2;
  localparam int unsigned E_ADDR  = 3;
  localparam int unsigned E_LEN   = 4;
  localparam int unsigned E_MISS  = 5;
  localparam int unsigned ERR_N   = 6;

  typedef enum logic [1:0] {
    SRC_OCM  = 2'd0,
    SRC_XIP4 = 2'd1,
    SRC_XIP8 = 2'd2,
    SRC_BAD  = 2'd3
  } boot_src_e;
endpackage

// File: rtl/hdr_sum_acc.sv
module hdr_sum_acc #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [DW-1:0] dat_i,
  output logic [DW-1:0] sum_o
);
  logic [DW-1:0] sum_q, sum_d;
  logic          sum_en;

  always_comb begin
    sum_en = clr_i | add_i;
    sum_d  = clr_i ? '0 : sum_q + dat_i;  // wraps modulo 2^DW
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (sum_en) sum_q <= sum_d;
  end

  assign sum_o = sum_q;

  p_sum_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sum_o == '0));
  p_sum_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !add_i) |=> $stable(sum_o));
endmodule

// File: rtl/hdr_field_cap.sv
module hdr_field_cap import hdr_chk_pkg::*; #(
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    dat_i,
  output logic [DW-1:0]    img_o,
  output logic [DW-1:0]    start_o,
  output logic [DW-1:0]    total_o,
  output logic [DW-1:0]    rsv_a_o,
  output logic [DW-1:0]    rsv_b_o,
  output logic [NSUM-1:0]  seen_o
);
  logic [DW-1:0]   img_q, start_q, total_q, rsv_a_q, rsv_b_q;
  logic            img_en, start_en, total_en, rsv_a_en, rsv_b_en, seen_en;
  logic [DW-1:0]   fld_d;
  logic [NSUM-1:0] seen_q, seen_d;

  always_comb begin
    fld_d    = clr_i ? '0 : dat_i;
    img_en   = clr_i | (we_i && idx_i == IDX_W'(IDX_IMG));
    rsv_a_en = clr_i | (we_i && idx_i == IDX_W'(IDX_RSV_A));
    start_en = clr_i | (we_i && idx_i == IDX_W'(IDX_START));
    total_en = clr_i | (we_i && idx_i == IDX_W'(IDX_TOTAL));
    rsv_b_en = clr_i | (we_i && idx_i == IDX_W'(IDX_RSV_B));
    seen_en  = clr_i | we_i;
    for (int i = 0; i < int'(NSUM); i++)
      seen_d[i] = !clr_i && (seen_q[i] || idx_i == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img_q   <= '0;
      start_q <= '0;
      total_q <= '0;
      rsv_a_q <= '0;
      rsv_b_q <= '0;
      seen_q  <= '0;
    end else begin
      if (img_en)   img_q   <= fld_d;
      if (start_en) start_q <= fld_d;
      if (total_en) total_q <= fld_d;
      if (rsv_a_en) rsv_a_q <= fld_d;
      if (rsv_b_en) rsv_b_q <= fld_d;
      if (seen_en)  seen_q  <= seen_d;
    end
  end

  assign img_o   = img_q;
  assign start_o = start_q;
  assign total_o = total_q;
  assign rsv_a_o = rsv_a_q;
  assign rsv_b_o = rsv_b_q;
  assign seen_o  = seen_q;

  p_seen_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (seen_o == '0));
  p_seen_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && we_i) |=> ($countones(seen_o) >= $countones($past(seen_o))));
endmodule

// File: rtl/hdr_rule_eval.sv
module hdr_rule_eval import hdr_chk_pkg::*; #(
  parameter int unsigned   DW         = 32,
  parameter int unsigned   ALIGN_BITS = 6,
  parameter logic [DW-1:0] OCM_LIMIT  = 'h0003_0000,
  parameter logic [DW-1:0] XIP4_LIMIT = 'h0100_0000,
  parameter logic [DW-1:0] XIP8_LIMIT = 'h0200_0000
) (
  input  logic [DW-1:0]    sum_i,
  input  logic [DW-1:0]    csum_i,
  input  logic [DW-1:0]    img_i,
  input  logic [DW-1:0]    start_i,
  input  logic [DW-1:0]    total_i,
  input  logic [DW-1:0]    rsv_a_i,
  input  logic [DW-1:0]    rsv_b_i,
  input  logic [NSUM-1:0]  seen_i,
  input  logic             secure_i,
  input  logic [1:0]       src_i,
  output logic [ERR_N-1:0] err_o
);
  logic addr_bad;

  always_comb begin
    case (boot_src_e'(src_i))
      SRC_OCM:  addr_bad = secure_i ? (start_i != '0) : (start_i >= OCM_LIMIT);
      SRC_XIP4: addr_bad = start_i >= XIP4_LIMIT;
      SRC_XIP8: addr_bad = start_i >= XIP8_LIMIT;
      default:  addr_bad = 1'b1;
    endcase
    err_o          = '0;
    err_o[E_CSUM]  = (~sum_i) != csum_i;
    err_o[E_RSV]   = (rsv_a_i != '0) || (rsv_b_i != '0);
    err_o[E_ALIGN] = start_i[ALIGN_BITS-1:0] != '0;
    err_o[E_ADDR]  = addr_bad;
    err_o[E_LEN]   = secure_i ? (total_i <= img_i) : (total_i != img_i);
    err_o[E_MISS]  = !(&seen_i);
  end
endmodule

// File: rtl/boot_hdr_check.sv
module boot_hdr_check import hdr_chk_pkg::*; #(
  parameter int unsigned     DW         = 32,
  parameter int unsigned     OFF_W      = 12,
  parameter int unsigned     ALIGN_BITS = 6,
  parameter logic [DW-1:0]   OCM_LIMIT  = 'h0003_0000,
  parameter logic [DW-1:0]   XIP4_LIMIT = 'h0100_0000,
  parameter logic [DW-1:0]   XIP8_LIMIT = 'h0200_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             word_vld_i,
  input  logic [OFF_W-1:0] word_off_i,
  input  logic [DW-1:0]    word_dat_i,
  input  logic             secure_i,
  input  logic [1:0]       src_sel_i,
  output logic             done_o,
  output logic [ERR_N-1:0] err_o,
  output logic             pass_o
);
  logic [OFF_W-1:0] rel_off;
  logic [IDX_W-1:0] idx;
  logic             in_win, acc_en, add_en, is_csum;
  logic [DW-1:0]    sum, img, start_addr, total, rsv_a, rsv_b;
  logic [NSUM-1:0]  seen;
  logic [ERR_N-1:0] err_now;

  logic             armed_q, armed_d, done_q, done_d, pass_q, pass_d;
  logic [ERR_N-1:0] err_q, err_d;

  // offset decode: aligned words inside the header window only
  always_comb begin
    rel_off = word_off_i - OFF_W'(HDR_FIRST);
    idx     = IDX_W'(rel_off >> 2);
    in_win  = word_vld_i && (word_off_i[1:0] == 2'b00) &&
              (word_off_i >= OFF_W'(HDR_FIRST)) && (word_off_i <= OFF_W'(HDR_CSUM));
    acc_en  = armed_q && !start_i && in_win;
    add_en  = acc_en && (idx < IDX_W'(NSUM));
    is_csum = acc_en && (idx == IDX_W'(IDX_CSUM));
  end

  hdr_sum_acc #(.DW(DW)) u_sum (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .add_i(add_en),
    .dat_i(word_dat_i), .sum_o(sum)
  );

  hdr_field_cap #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i), .we_i(add_en), .idx_i(idx),
    .dat_i(word_dat_i), .img_o(img), .start_o(start_addr), .total_o(total),
    .rsv_a_o(rsv_a), .rsv_b_o(rsv_b), .seen_o(seen)
  );

  hdr_rule_eval #(
    .DW(DW), .ALIGN_BITS(ALIGN_BITS), .OCM_LIMIT(OCM_LIMIT),
    .XIP4_LIMIT(XIP4_LIMIT), .XIP8_LIMIT(XIP8_LIMIT)
  ) u_eval (
    .sum_i(sum), .csum_i(word_dat_i), .img_i(img), .start_i(start_addr),
    .total_i(total), .rsv_a_i(rsv_a), .rsv_b_i(rsv_b), .seen_i(seen),
    .secure_i(secure_i), .src_i(src_sel_i), .err_o(err_now)
  );

  // next-state
  always_comb begin
    armed_d = armed_q;
    done_d  = 1'b0;
    pass_d  = pass_q;
    err_d   = err_q;
    if (start_i) begin
      armed_d = 1'b1;
      pass_d  = 1'b0;
      err_d   = '0;
    end else if (is_csum) begin
      armed_d = 1'b0;
      done_d  = 1'b1;
      pass_d  = (err_now == '0);
      err_d   = err_now;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      err_q   <= '0;
    end else begin
      armed_q <= armed_d;
      done_q  <= done_d;
      pass_q  <= pass_d;
      err_q   <= err_d;
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;
  assign err_o  = err_q;

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !armed_q);
  p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!pass_o && err_o == '0 && !done_o));
  p_idle_nodone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !start_i) |=> !done_o);
  p_miss_nopass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o[E_MISS] |-> !pass_o);
endmodule

// File: tb/sim_boot_hdr_check.sv
`timescale 1ns/1ps
module sim_boot_hdr_check;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, word_vld_i, secure_i;
  logic [11:0] word_off_i;
  logic [31:0] word_dat_i;
  logic [1:0]  src_sel_i;
  logic        done_o, pass_o;
  logic [5:0]  err_o;
  int          nchecks = 0;
  int          nerrors = 0;

  // error bits: 0 checksum, 1 reserved, 2 align, 3 address, 4 length, 5 missing
  localparam logic [5:0] B_CK = 6'h01, B_RSV = 6'h02, B_AL = 6'h04,
                         B_AD = 6'h08, B_LEN = 6'h10, B_MISS = 6'h20;

  always #2.5 clk = ~clk;

  boot_hdr_check u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_vld_i(word_vld_i),
    .word_off_i(word_off_i), .word_dat_i(word_dat_i), .secure_i(secure_i),
    .src_sel_i(src_sel_i), .done_o(done_o), .err_o(err_o), .pass_o(pass_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerrors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [11:0] off, input logic [31:0] dat);
    @(negedge clk);
    word_vld_i = 1'b1; word_off_i = off; word_dat_i = dat;
    @(negedge clk);
    word_vld_i = 1'b0;
  endtask

  task automatic pulse_start(input bit with_word, input logic [31:0] dat);
    @(negedge clk);
    start_i = 1'b1;
    if (with_word) begin
      word_vld_i = 1'b1; word_off_i = 12'h020; word_dat_i = dat;
    end
    @(negedge clk);
    start_i = 1'b0; word_vld_i = 1'b0;
  endtask

  // one header; skip < 0 sends every word
  task automatic run_hdr(input string req, input bit sec, input logic [1:0] sel,
                         input logic [31:0] img, input logic [31:0] tot,
                         input logic [31:0] st, input logic [31:0] r38,
                         input logic [31:0] r44, input bit bad_ck, input bit rev,
                         input int skip, input bit collide, input logic [5:0] exp);
    logic [31:0] w [11];
    logic [31:0] s;
    s = 32'h0;
    for (int i = 0; i < 5; i++) w[i] = 32'hA5A5_0001 + 32'h1111_0000 * i;
    w[5] = img; w[6] = r38; w[7] = st; w[8] = tot; w[9] = r44;
    for (int i = 0; i < 10; i++) s = s + w[i];
    w[10] = ~s ^ (bad_ck ? 32'h1 : 32'h0);
    secure_i = sec; src_sel_i = sel;
    pulse_start(collide, w[0]);
    if (rev) begin
      send_word(12'h010, 32'hDEAD_BEEF);
      send_word(12'h04C, 32'h1234_5678);
      send_word(12'h022, 32'hFFFF_FFFF);
    end
    for (int i = 0; i < 10; i++) begin
      int j;
      j = rev ? 9 - i : i;
      if (j != skip && !(collide && j == 0)) send_word(12'h020 + 12'(4 * j), w[j]);
    end
    chk({req, " R8 no done before checksum"}, {31'h0, done_o}, 32'h0);
    send_word(12'h048, w[10]);
    chk({req, " R8 done pulse"}, {31'h0, done_o}, 32'h1);
    chk({req, " err"}, {26'h0, err_o}, {26'h0, exp});
    chk({req, " R8 pass"}, {31'h0, pass_o}, {31'h0, exp == 6'h0});
    @(negedge clk);
    chk({req, " R8 done one cycle"}, {31'h0, done_o}, 32'h0);
    chk({req, " R8 err held"}, {26'h0, err_o}, {26'h0, exp});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; word_vld_i = 1'b0; word_off_i = '0;
    word_dat_i = '0; secure_i = 1'b0; src_sel_i = 2'd0;
    repeat (3) @(negedge clk);
    chk("R10 reset done", {31'h0, done_o}, 32'h0);
    chk("R10 reset pass", {31'h0, pass_o}, 32'h0);
    chk("R10 reset err", {26'h0, err_o}, 32'h0);
    rst_n = 1'b1;
    send_word(12'h048, 32'h0);  // before any start: ignored
    chk("R9 word before start ignored", {31'h0, done_o}, 32'h0);
  endtask

  task automatic t_basic();
    run_hdr("R1 R4 good nonsecure", 0, 2'd0, 32'h8000, 32'h8000, 32'h1000, 0, 0, 0, 0, -1, 0, 6'h0);
    run_hdr("R1 bad checksum", 0, 2'd0, 32'h8000, 32'h8000, 32'h1000, 0, 0, 1, 0, -1, 0, B_CK);
    run_hdr("R2 reserved 0x038", 0, 2'd0, 32'h8000, 32'h8000, 32'h1000, 32'h5, 0, 0, 0, -1, 0, B_RSV);
    run_hdr("R2 reserved 0x044", 0, 2'd0, 32'h8000, 32'h8000, 32'h1000, 0, 32'h100, 0, 0, -1, 0, B_RSV);
    run_hdr("R3 misaligned", 0, 2'd0, 32'h8000, 32'h8000, 32'h1020, 0, 0, 0, 0, -1, 0, B_AL);
    run_hdr("R3 R4 secure misaligned", 1, 2'd0, 32'h8000, 32'h9000, 32'h1020, 0, 0, 0, 0, -1, 0, B_AL | B_AD);
  endtask

  task automatic t_ocm();
    run_hdr("R4 ns at limit", 0, 2'd0, 32'h8000, 32'h8000, 32'h30000, 0, 0, 0, 0, -1, 0, B_AD);
    run_hdr("R4 ns below limit", 0, 2'd0, 32'h8000, 32'h8000, 32'h2FFC0, 0, 0, 0, 0, -1, 0, 6'h0);
    run_hdr("R4 secure nonzero", 1, 2'd0, 32'h8000, 32'h9000, 32'h40, 0, 0, 0, 0, -1, 0, B_AD);
    run_hdr("R4 R6 secure good", 1, 2'd0, 32'h8000, 32'h9000, 32'h0, 0, 0, 0, 0, -1, 0, 6'h0);
  endtask

  task automatic t_xip();
    run_hdr("R5 x4 below", 0, 2'd1, 32'h8000, 32'h8000, 32'h00FF_FFC0, 0, 0, 0, 0, -1, 0, 6'h0);
    run_hdr("R5 x4 at 16MB", 0, 2'd1, 32'h8000, 32'h8000, 32'h0100_0000, 0, 0, 0, 0, -1, 0, B_AD);
    run_hdr("R5 x8 at 16MB", 0, 2'd2, 32'h8000, 32'h8000, 32'h0100_0000, 0, 0, 0, 0, -1, 0, 6'h0);
    run_hdr("R5 x8 at 32MB", 0, 2'd2, 32'h8000, 32'h8000, 32'h0200_0000, 0, 0, 0, 0, -1, 0, B_AD);
    run_hdr("R5 source 3", 0, 2'd3, 32'h8000, 32'h8000, 32'h0, 0, 0, 0, 0, -1, 0, B_AD);
  endtask

  task automatic t_len();
    run_hdr("R6 ns unequal", 0, 2'd0, 32'h8000, 32'h8004, 32'h0, 0, 0, 0, 0, -1, 0, B_LEN);
    run_hdr("R6 secure equal", 1, 2'd0, 32'h8000, 32'h8000, 32'h0, 0, 0, 0, 0, -1, 0, B_LEN);
    run_hdr("R6 secure smaller", 1, 2'd0, 32'h8000, 32'h7FFC, 32'h0, 0, 0, 0, 0, -1, 0, B_LEN);
  endtask

  task automatic t_missing();
    run_hdr("R7 missing 0x02C", 0, 2'd0, 32'h8000, 32'h8000, 32'h1000, 0, 0, 0, 0, 3, 0, B_MISS | B_CK);
    run_hdr("R9 R7 start collides with word", 0, 2'd0, 32'h8000, 32'h8000, 32'h1000, 0, 0, 0, 0, -1, 1, B_MISS | B_CK);
  endtask

  task automatic t_order_hold();
    run_hdr("R9 reversed plus outside words", 0, 2'd0, 32'h8000, 32'h8000, 32'h1000, 0, 0, 0, 1, -1, 0, 6'h0);
    repeat (4) @(negedge clk);
    chk("R8 pass held", {31'h0, pass_o}, 32'h1);
    send_word(12'h048, 32'h0);
    chk("R9 word after done ignored", {31'h0, done_o}, 32'h0);
    chk("R9 pass kept after stray word", {31'h0, pass_o}, 32'h1);
    run_hdr("R9 failing header before clear", 0, 2'd0, 32'h8000, 32'h8004, 32'h1000, 0, 0, 0, 0, -1, 0, B_LEN);
    pulse_start(0, 32'h0);
    chk("R9 start clears err", {26'h0, err_o}, 32'h0);
    chk("R9 start clears pass", {31'h0, pass_o}, 32'h0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_ocm();
    t_xip();
    t_len();
    t_missing();
    t_order_hold();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchecks++; nerrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end
endmodule